// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a stereo serial audio stream as a slave. It takes a bit clock, a frame clock that alternates between the two channels, and a serial data line. All three are oversampled by the block's own system clock. The stream can be framed in five ways: 16-bit or 20-bit right-justified, 24-bit left-justified, 24-bit I2S, or 24-bit right-justified. A 3-bit format select picks the framing.

For each complete stereo frame the block presents a 24-bit two's-complement left sample and right sample, together with a one-cycle valid strobe. Shorter words are placed in the upper bits of the 24-bit output. One shift engine serves every framing. In the right-justified framings, the word is taken from the last bits before the next frame-clock edge, so a half-frame may have any number of bit-clock periods at or above the word length. In the other framings, the word is taken from a fixed window after the edge.

A new format select value takes effect only when a right half-frame closes. A pair is therefore never decoded with two different framings.

Top module: `pcm_frame_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sample_valid` is 0 and both sample outputs are 0. The active framing after reset is 24-bit left-justified (code 010), whatever `fmt_sel` holds.
- R2: Serial bits are taken on rising edges of `bit_clk_in`, MSB first, in two's complement. A half-frame starts at the rising bit-clock edge where `frame_clk_in` differs from its level at the previous rising edge. That bit has index 0 within the half-frame.
- R3: With code 010 (24-bit left-justified), the sample is bits 0 to 23 of the half-frame. Later bits have no effect on the output.
- R4: With code 011 (I2S), the sample is bits 1 to 24 of the half-frame, so the MSB comes one bit-clock period after the frame-clock edge. Bit 0 and bits after 24 are ignored. A half-frame needs at least 25 periods.
- R5: With code 000 (16-bit right-justified), the sample is the last 16 bits of the half-frame, LSB last. The output is those 16 bits in bits 23:8, with 8 zero bits below. Earlier bits are ignored. A half-frame needs at least 16 periods.
- R6: With code 001 (20-bit right-justified), the sample is the last 20 bits of the half-frame. The output is those 20 bits in bits 23:4, with 4 zero bits below. Earlier bits are ignored.
- R7: With code 100 (24-bit right-justified), the sample is the last 24 bits of the half-frame. The number of periods may differ from half-frame to half-frame.
- R8: `fmt_sel` is loaded into the active framing only at the edge that closes a right half-frame. The codes 101, 110 and 111 are ignored, and the previous framing stays active.
- R9: When a right half-frame closes after a captured left half-frame, both samples are updated and `sample_valid` is high for exactly one cycle. At all other times, the outputs hold and `sample_valid` is 0.
- R10: In the justified framings (codes 000, 001, 010, 100), a high frame clock marks the left channel. With code 011, a low frame clock marks the left channel. The partial half-frame before the first frame-clock edge after reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_in | input | 1 | Serial bit clock |
| frame_clk_in | input | 1 | Frame clock selecting the channel |
| data_in | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Framing select: 000 RJ16, 001 RJ20, 010 LJ24, 011 I2S, 100 RJ24 |
| left_sample | output | SAMPLE_W | Left-channel sample, two's complement |
| right_sample | output | SAMPLE_W | Right-channel sample, two's complement |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench builds the block with its default values: 24-bit samples, a 6-bit bit-position counter that saturates at 63, and two synchronizer stages. The counter width lets half-frames of 16 to 40 periods be mixed freely, including the exact minimum for each framing. It also allows halves of unequal length within one frame, and a 25-period I2S half in which the LSB is the final bit. With two synchronizer stages and eight system clocks per bit period, every polarity swap between framings can be exercised, as can every ignored-code case and the one-cycle strobe.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    typedef enum logic [2:0] {
        FMT_RJ16  = 3'b000,
        FMT_RJ20  = 3'b001,
        FMT_LJ24  = 3'b010,
        FMT_I2S24 = 3'b011,
        FMT_RJ24  = 3'b100
    } fmt_e;

    localparam int RJ16_BITS = 16;
    localparam int RJ20_BITS = 20;

    // Left channel: high frame clock in justified framings, low in I2S.
    function automatic logic half_is_left(input fmt_e fmt, input logic lvl);
        return (fmt == FMT_I2S24) ? ~lvl : lvl;
    endfunction

    function automatic logic code_is_legal(input logic [2:0] code);
        return code <= 3'b100;
    endfunction

endpackage

// File: rtl/pfr_sync.sv
module pfr_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         rise0
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic                     prev;
    } sync_st_t;

    sync_st_t sync_q, sync_d;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stg[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.stg[s] = sync_q.stg[s-1];
        end
        sync_d.prev = sync_q.stg[STAGES-1][0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout  = sync_q.stg[STAGES-1];
    assign rise0 = sync_q.stg[STAGES-1][0] & ~sync_q.prev;

endmodule

// File: rtl/pfr_framer.sv
module pfr_framer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             lvl,
    output logic [CNT_W-1:0] cur_idx,
    output logic             half_end,
    output logic             ended_lvl
);

    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic             seen;
        logic [CNT_W-1:0] idx;
    } frm_st_t;

    frm_st_t frm_q, frm_d;
    logic    lvl_flip;

    always_comb begin
        frm_d    = frm_q;
        lvl_flip = rise && (lvl != frm_q.lvl);
        if (lvl_flip) begin
            cur_idx = '0;
        end else if (frm_q.idx == IDX_MAX) begin
            cur_idx = IDX_MAX;
        end else begin
            cur_idx = frm_q.idx + CNT_W'(1);
        end
        if (rise) begin
            frm_d.idx = cur_idx;
            frm_d.lvl = lvl;
            if (lvl_flip) begin
                frm_d.seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign half_end  = lvl_flip && frm_q.seen;
    assign ended_lvl = frm_q.lvl;

endmodule

// File: rtl/pfr_shifter.sv
module pfr_shifter
    import pfr_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                bit_in,
    input  logic [CNT_W-1:0]    cur_idx,
    input  fmt_e                win_fmt,
    input  fmt_e                out_fmt,
    output logic [SAMPLE_W-1:0] word
);

    localparam logic [CNT_W-1:0] LJ_LAST  = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(SAMPLE_W);

    generate
        if ((2 ** CNT_W) <= SAMPLE_W + 1) begin : g_bad_cnt
            $error("CNT_W too narrow for the capture window");
        end
    endgenerate

    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
    } shf_st_t;

    shf_st_t shf_q, shf_d;
    logic    in_win;
    int      pad;

    always_comb begin
        shf_d = shf_q;
        unique case (win_fmt)
            FMT_LJ24:  in_win = (cur_idx <= LJ_LAST);
            FMT_I2S24: in_win = (cur_idx != '0) && (cur_idx <= I2S_LAST);
            default:   in_win = 1'b1;
        endcase
        if (rise && in_win) begin
            shf_d.sh = {shf_q.sh[SAMPLE_W-2:0], bit_in};
        end
    end

    always_comb begin
        unique case (out_fmt)
            FMT_RJ16: pad = SAMPLE_W - RJ16_BITS;
            FMT_RJ20: pad = SAMPLE_W - RJ20_BITS;
            default:  pad = 0;
        endcase
        word = shf_q.sh << pad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

endmodule

// File: rtl/pfr_pair.sv
module pfr_pair
    import pfr_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                half_end,
    input  logic                ended_lvl,
    input  logic [SAMPLE_W-1:0] word,
    input  logic [2:0]          fmt_in,
    output fmt_e                fmt_now,
    output fmt_e                fmt_next,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid_out
);

    typedef struct packed {
        fmt_e                fmt;
        logic                have_left;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } pair_st_t;

    pair_st_t pair_q, pair_d;

    always_comb begin
        pair_d       = pair_q;
        pair_d.valid = 1'b0;
        if (half_end) begin
            if (half_is_left(pair_q.fmt, ended_lvl)) begin
                pair_d.hold      = word;
                pair_d.have_left = 1'b1;
            end else begin
                if (pair_q.have_left) begin
                    pair_d.left  = pair_q.hold;
                    pair_d.right = word;
                    pair_d.valid = 1'b1;
                end
                pair_d.have_left = 1'b0;
                if (code_is_legal(fmt_in)) begin
                    pair_d.fmt = fmt_e'(fmt_in);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q     <= '0;
            pair_q.fmt <= FMT_LJ24;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign fmt_now   = pair_q.fmt;
    assign fmt_next  = pair_d.fmt;
    assign left_out  = pair_q.left;
    assign right_out = pair_q.right;
    assign valid_out = pair_q.valid;

endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx
    import pfr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk_in,
    input  logic                frame_clk_in,
    input  logic                data_in,
    input  logic [2:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid
);

    localparam int LINES = 3;

    logic [LINES-1:0]    pins_sync;
    logic                bit_rise;
    logic [CNT_W-1:0]    cur_idx;
    logic                half_end;
    logic                ended_lvl;
    logic [SAMPLE_W-1:0] word;
    fmt_e                fmt_now;
    fmt_e                fmt_next;
    logic [2:0]          act_fmt;

    pfr_sync #(
        .STAGES (SYNC_STAGES),
        .W      (LINES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({data_in, frame_clk_in, bit_clk_in}),
        .dout  (pins_sync),
        .rise0 (bit_rise)
    );

    pfr_framer #(
        .CNT_W (CNT_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .rise      (bit_rise),
        .lvl       (pins_sync[1]),
        .cur_idx   (cur_idx),
        .half_end  (half_end),
        .ended_lvl (ended_lvl)
    );

    pfr_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .rise    (bit_rise),
        .bit_in  (pins_sync[2]),
        .cur_idx (cur_idx),
        .win_fmt (fmt_next),
        .out_fmt (fmt_now),
        .word    (word)
    );

    pfr_pair #(
        .SAMPLE_W (SAMPLE_W)
    ) u_pair (
        .clk       (clk),
        .rst       (rst),
        .half_end  (half_end),
        .ended_lvl (ended_lvl),
        .word      (word),
        .fmt_in    (fmt_sel),
        .fmt_now   (fmt_now),
        .fmt_next  (fmt_next),
        .left_out  (left_sample),
        .right_out (right_sample),
        .valid_out (sample_valid)
    );

    assign act_fmt = fmt_now;

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                valid,
    input logic [SAMPLE_W-1:0] left,
    input logic [SAMPLE_W-1:0] right,
    input logic                bit_rise,
    input logic                half_end,
    input logic [2:0]          act_fmt
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!valid && left == '0 && right == '0));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_valid_after_edge_R9: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(bit_rise));

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(left) && $stable(right)));

    assert_rj16_pad_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(act_fmt) == 3'b000) |-> (left[7:0] == 8'h00 && right[7:0] == 8'h00));

    assert_rj20_pad_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(act_fmt) == 3'b001) |-> (left[3:0] == 4'h0 && right[3:0] == 4'h0));

    assert_fmt_change_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_fmt) |-> $past(half_end));

    assert_fmt_legal_R8: assert property (@(posedge clk) disable iff (rst)
        act_fmt <= 3'b100);

endmodule

bind pcm_frame_rx pfr_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid    (sample_valid),
    .left     (left_sample),
    .right    (right_sample),
    .bit_rise (bit_rise),
    .half_end (half_end),
    .act_fmt  (act_fmt)
);

// File: tb/tb_pcm_frame_rx.sv
module tb_pcm_frame_rx;

    logic        clk = 1'b0;
    logic        rst;
    logic        bclk, lrclk, sdata;
    logic [2:0]  fmt_pin;
    logic [23:0] left_sample, right_sample;
    logic        sample_valid;

    always #10 clk = ~clk;

    pcm_frame_rx dut (
        .clk          (clk),
        .rst          (rst),
        .bit_clk_in   (bclk),
        .frame_clk_in (lrclk),
        .data_in      (sdata),
        .fmt_sel      (fmt_pin),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .sample_valid (sample_valid)
    );

    typedef struct packed {
        logic [2:0]  f;
        logic [6:0]  p;
        logic [23:0] l;
        logic [23:0] r;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{3'b010, 7'd32, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
        '{3'b010, 7'd24, 24'h800000, 24'h7FFFFF, 24'h800000, 24'h7FFFFF},
        '{3'b000, 7'd16, 24'h008001, 24'h007FFF, 24'h800100, 24'h7FFF00},
        '{3'b000, 7'd32, 24'h001234, 24'h00ABCD, 24'h123400, 24'hABCD00},
        '{3'b001, 7'd20, 24'h080000, 24'h012345, 24'h800000, 24'h123450},
        '{3'b001, 7'd32, 24'h0FFFFF, 24'h000001, 24'hFFFFF0, 24'h000010},
        '{3'b100, 7'd24, 24'hA5A5A5, 24'h5A5A5A, 24'hA5A5A5, 24'h5A5A5A},
        '{3'b100, 7'd32, 24'h000001, 24'hFFFFFF, 24'h000001, 24'hFFFFFF},
        '{3'b011, 7'd32, 24'hC0FFEE, 24'h0BEEF0, 24'hC0FFEE, 24'h0BEEF0},
        '{3'b011, 7'd25, 24'h800001, 24'h7FFFFE, 24'h800001, 24'h7FFFFE},
        '{3'b010, 7'd28, 24'h000000, 24'h400000, 24'h000000, 24'h400000}
    };

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic        cur_lvl;
    logic [23:0] exp_l [64];
    logic [23:0] exp_r [64];
    logic [2:0]  exp_f [64];
    logic [23:0] got_l [64];
    logic [23:0] got_r [64];
    int          n_exp = 0;
    int          n_got = 0;
    int          pulse_err = 0;
    logic        prev_v = 1'b0;

    always @(negedge clk) begin
        if (sample_valid) begin
            if (n_got < 64) begin
                got_l[n_got] = left_sample;
                got_r[n_got] = right_sample;
            end
            n_got++;
            if (prev_v) pulse_err++;
        end
        prev_v = sample_valid;
    end

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'b000:  return "R5";
            3'b001:  return "R6";
            3'b011:  return "R4 R10";
            3'b100:  return "R7";
            default: return "R3";
        endcase
    endfunction

    function automatic logic bitval(input logic [2:0] f, input int p, input logic [23:0] s, input int i);
        int n;
        n = (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
        case (f)
            3'b010:  return (i < 24) ? s[23-i] : 1'b1;
            3'b011:  return (i >= 1 && i <= 24) ? s[24-i] : 1'b1;
            default: return (i >= p - n) ? s[p-1-i] : 1'b1;
        endcase
    endfunction

    task automatic send_bit(input logic lv, input logic b);
        @(negedge clk);
        lrclk = lv;
        sdata = b;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic send_half(input logic lv, input logic [2:0] f, input int p, input logic [23:0] s);
        for (int i = 0; i < p; i++) send_bit(lv, bitval(f, p, s, i));
        cur_lvl = lv;
    endtask

    task automatic gen_frame(input logic [2:0] f, input int pl, input int pr,
                             input logic [23:0] l, input logic [23:0] r,
                             input logic [23:0] el, input logic [23:0] er);
        logic left_lvl;
        left_lvl = (f == 3'b011) ? 1'b0 : 1'b1;
        if (cur_lvl == left_lvl) send_half(~left_lvl, f, 8, 24'h0);
        send_half(left_lvl, f, pl, l);
        send_half(~left_lvl, f, pr, r);
        exp_l[n_exp] = el;
        exp_r[n_exp] = er;
        exp_f[n_exp] = f;
        n_exp++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        fmt_pin = 3'b000; cur_lvl = 1'b0;
        repeat (5) @(negedge clk);
        chk(sample_valid == 1'b0, "R1 valid", {23'h0, sample_valid}, 24'h0);
        chk(left_sample == 24'h0, "R1 left", left_sample, 24'h0);
        chk(right_sample == 24'h0, "R1 right", right_sample, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(sample_valid == 1'b0 && left_sample == 24'h0, "R1 after release", left_sample, 24'h0);

        // R10: partial low half before the first edge is discarded
        send_half(1'b0, 3'b010, 8, 24'hFFFFFF);
        // R8 / R1: select holds 000, first frame still decoded left-justified
        gen_frame(3'b010, 32, 32, 24'h13579B, 24'hECA864, 24'h13579B, 24'hECA864);
        // R8: 000 becomes active at the close of that frame
        gen_frame(3'b000, 32, 32, 24'h002468, 24'h009ABC, 24'h246800, 24'h9ABC00);

        for (int v = 0; v < NVEC; v++) begin
            fmt_pin = VECS[v].f;
            gen_frame(VECS[v].f, int'(VECS[v].p), int'(VECS[v].p),
                      VECS[v].l, VECS[v].r, VECS[v].el, VECS[v].er);
        end

        // R8: reserved code 111 is ignored, left-justified stays active
        fmt_pin = 3'b111;
        gen_frame(3'b010, 32, 32, 24'h0F0F0F, 24'hF0F0F0, 24'h0F0F0F, 24'hF0F0F0);
        gen_frame(3'b010, 26, 30, 24'h765432, 24'h89ABCD, 24'h765432, 24'h89ABCD);

        // R7: unequal half-frame lengths in 24-bit right-justified
        fmt_pin = 3'b100;
        gen_frame(3'b100, 30, 40, 24'h3C3C3C, 24'hC3C3C3, 24'h3C3C3C, 24'hC3C3C3);

        send_half(~cur_lvl, 3'b010, 8, 24'h0);
        repeat (40) @(negedge clk);

        chk(n_got == n_exp, "R9 pair count", 24'(n_got), 24'(n_exp));
        chk(pulse_err == 0, "R9 one-cycle strobe", 24'(pulse_err), 24'h0);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(got_l[i] == exp_l[i], {req_of(exp_f[i]), " R2 left"}, got_l[i], exp_l[i]);
            chk(got_r[i] == exp_r[i], {req_of(exp_f[i]), " R2 right"}, got_r[i], exp_r[i]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule